// File: doc/BRIEF.md
# Lock-Aware Tree Pseudo-LRU Victim Selector

This block chooses which way of an 8-way set-associative cache is replaced next. Each set has a 7-bit binary-tree pseudo-LRU state. A per-way lock vector folds into that tree, so that every node steers away from a subtree whose ways are all locked. The block decodes the resulting effective node bits straight into a one-hot victim and also gives the victim's binary index. A flag marks the case where all eight ways are locked and no victim may be used.

The set index addresses both the victim lookup and the state update. The victim is a combinational function of the stored state of the addressed set and the current lock vector. When `acc_valid` is high on a rising edge, the tree path of `acc_way` in that set is rewritten so that it points away from that way. Hits and fills use this same access port. The tag array, the data array and error protection sit outside the block.

Node numbering: node 0 is the root and chooses between ways 0-3 (value 0) and ways 4-7 (value 1). Node 1 chooses between ways 0-1 and 2-3, and node 2 between ways 4-5 and 6-7. Nodes 3, 4, 5 and 6 choose within the way pairs {0,1}, {2,3}, {4,5} and {6,7}. At every node a value of 0 selects the lower-numbered side.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset, every set's tree state is all zeros, so with no locks the victim of every set is way 0.
- R2: An access to way w in set s rewrites only the three nodes on w's path in that set, each pointing to the side that does not contain w. For example, an access to way 0 sets nodes 0, 1 and 3 to 1. Nodes off the path keep their values.
- R3: If ways 0-3 are all locked, the effective root value is 1. Otherwise, if ways 4-7 are all locked, it is 0. Otherwise it equals the stored root bit.
- R4: For node 1, the rule of R3 applies to the way pairs {0,1} and {2,3}. For node 2, it applies to the pairs {4,5} and {6,7}.
- R5: For each leaf node, a locked lower way forces 1. Otherwise a locked upper way forces 0. Otherwise the stored bit is used.
- R6: `victim_onehot` has exactly one bit set for every combination of state and locks, and `victim_idx` is the position of that bit.
- R7: While at least one way is unlocked, the victim is never a locked way.
- R8: `all_locked` is 1 exactly when all eight lock bits are 1. `victim_valid` equals `victim_req` AND NOT `all_locked`.
- R9: The victim depends on the stored state from before the current edge. An access changes the victim seen from the following cycle on.
- R10: An access changes only the addressed set. The victims of other sets are unaffected.
- R11: With `acc_valid` low, no set's state changes, whatever `acc_way` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all tree state |
| set_idx | input | SET_W | Set addressed for lookup and update |
| acc_valid | input | 1 | A hit or fill to `acc_way` occurs this cycle |
| acc_way | input | 3 | Way accessed (binary) |
| lock | input | 8 | Per-way lock bits, bit i locks way i |
| victim_req | input | 1 | Requester wants a victim this cycle |
| victim_onehot | output | 8 | One-hot victim way |
| victim_idx | output | 3 | Binary index of the victim way |
| victim_valid | output | 1 | Victim is usable: requested and not all ways locked |
| all_locked | output | 1 | All eight ways are locked |

## Verification
The hardest cases to reach are partly locked sets whose stored node bits point into a locked leaf or a locked pair. In these cases the effective bits must overrule the stored ones at more than one level at once. A fresh reset state points only at way 0. The stimulus therefore first runs random access sequences that scatter every set's tree across many values. It then applies random lock vectors weighted toward dense patterns, together with directed patterns that lock whole halves, whole pairs, single leaves and all eight ways. A reference that walks the tree, skipping any subtree whose ways are all locked, computes the expected victim in each case.

// File: rtl/plru_pkg.sv
package plru_pkg;
    localparam int WAYS      = 8;
    localparam int WAY_W     = $clog2(WAYS);
    localparam int NODES     = WAYS - 1;

    typedef logic [NODES-1:0] tree_t;
    typedef logic [WAYS-1:0]  wayvec_t;
    typedef logic [WAY_W-1:0] wayidx_t;

    // Rewrite the three nodes on the path of way w so each points away from w.
    function automatic tree_t path_touch(input tree_t cur, input wayidx_t w);
        tree_t nxt;
        int    mid;
        int    leaf;
        nxt    = cur;
        mid    = 1 + int'(w[2]);
        leaf   = 3 + int'(w[2:1]);
        nxt[0]    = ~w[2];
        nxt[mid]  = ~w[1];
        nxt[leaf] = ~w[0];
        return nxt;
    endfunction
endpackage

// File: rtl/plru_eff_bits.sv
module plru_eff_bits
    import plru_pkg::*;
(
    input  tree_t   stored,
    input  wayvec_t lk,
    output tree_t   eff
);
    logic lo_half, hi_half;
    logic [3:0] pair_full;

    always_comb begin
        lo_half = &lk[3:0];
        hi_half = &lk[7:4];
        for (int k = 0; k < 4; k++) begin
            pair_full[k] = lk[2*k] & lk[2*k+1];
        end
        // root
        eff[0] = lo_half | (stored[0] & ~hi_half);
        // middle level
        eff[1] = pair_full[0] | (stored[1] & ~pair_full[1]);
        eff[2] = pair_full[2] | (stored[2] & ~pair_full[3]);
        // leaves
        for (int k = 0; k < 4; k++) begin
            eff[3+k] = lk[2*k] | (stored[3+k] & ~lk[2*k+1]);
        end
    end
endmodule

// File: rtl/plru_decode.sv
module plru_decode
    import plru_pkg::*;
(
    input  tree_t   eff,
    output wayvec_t onehot,
    output wayidx_t idx
);
    always_comb begin
        onehot[0] = ~eff[0] & ~eff[1] & ~eff[3];
        onehot[1] = ~eff[0] & ~eff[1] &  eff[3];
        onehot[2] = ~eff[0] &  eff[1] & ~eff[4];
        onehot[3] = ~eff[0] &  eff[1] &  eff[4];
        onehot[4] =  eff[0] & ~eff[2] & ~eff[5];
        onehot[5] =  eff[0] & ~eff[2] &  eff[5];
        onehot[6] =  eff[0] &  eff[2] & ~eff[6];
        onehot[7] =  eff[0] &  eff[2] &  eff[6];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (onehot[i]) idx = idx | wayidx_t'(i);
        end
    end
endmodule

// File: rtl/plru_state_store.sv
module plru_state_store
    import plru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] set_sel,
    input  wayidx_t          touch_way,
    output tree_t            cur_state
);
    tree_t st_q [NUM_SETS];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g] <= '0;
            end else if (touch_en && (set_sel == SET_W'(g))) begin
                st_q[g] <= path_touch(st_q[g], touch_way);
            end
        end
    end

    always_comb begin
        cur_state = '0;
        for (int i = 0; i < NUM_SETS; i++) begin
            if (set_sel == SET_W'(i)) cur_state = st_q[i];
        end
    end
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
    import plru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             acc_valid,
    input  logic [2:0]       acc_way,
    input  logic [7:0]       lock,
    input  logic             victim_req,
    output logic [7:0]       victim_onehot,
    output logic [2:0]       victim_idx,
    output logic             victim_valid,
    output logic             all_locked
);
    tree_t stored_bits;
    tree_t eff_bits;

    plru_state_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (acc_valid),
        .set_sel   (set_idx),
        .touch_way (acc_way),
        .cur_state (stored_bits)
    );

    plru_eff_bits eff_i (
        .stored (stored_bits),
        .lk     (lock),
        .eff    (eff_bits)
    );

    plru_decode dec_i (
        .eff    (eff_bits),
        .onehot (victim_onehot),
        .idx    (victim_idx)
    );

    always_comb begin
        all_locked   = &lock;
        victim_valid = victim_req & ~all_locked;
    end
endmodule

// File: rtl/plru_victim_sel_chk.sv
module plru_victim_sel_chk #(
    parameter int SET_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SET_W-1:0] set_idx,
    input logic             acc_valid,
    input logic [2:0]       acc_way,
    input logic [7:0]       lock,
    input logic             victim_req,
    input logic [7:0]       victim_onehot,
    input logic [2:0]       victim_idx,
    input logic             victim_valid,
    input logic             all_locked
);
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(victim_onehot) == 1);

    p_idx_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        victim_onehot[victim_idx]);

    p_skip_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !all_locked |-> ((victim_onehot & lock) == 8'h00));

    p_no_valid_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_locked |-> !victim_valid);

    p_no_valid_unreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_req |-> !victim_valid);

    p_moved_away_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (set_idx != $past(set_idx) || lock != 8'h00
                       || victim_idx != $past(acc_way)));
endmodule

bind plru_victim_sel plru_victim_sel_chk #(.SET_W(SET_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_idx       (set_idx),
    .acc_valid     (acc_valid),
    .acc_way       (acc_way),
    .lock          (lock),
    .victim_req    (victim_req),
    .victim_onehot (victim_onehot),
    .victim_idx    (victim_idx),
    .victim_valid  (victim_valid),
    .all_locked    (all_locked)
);

// File: tb/plru_victim_sel_tb_top.sv
module plru_victim_sel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 16;
    localparam int SW         = $clog2(NSETS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] set_idx = '0;
    logic          acc_valid = 1'b0;
    logic [2:0]    acc_way = '0;
    logic [7:0]    lock = '0;
    logic          victim_req = 1'b0;
    logic [7:0]    victim_onehot;
    logic [2:0]    victim_idx;
    logic          victim_valid;
    logic          all_locked;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [6:0] model [NSETS];

    always #(CLK_PERIOD/2) clk = ~clk;

    plru_victim_sel #(.NUM_SETS(NSETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_valid(acc_valid),
        .acc_way(acc_way), .lock(lock), .victim_req(victim_req),
        .victim_onehot(victim_onehot), .victim_idx(victim_idx),
        .victim_valid(victim_valid), .all_locked(all_locked)
    );

    function automatic logic [6:0] ref_touch(input logic [6:0] p, input logic [2:0] w);
        logic [6:0] r = p;
        r[0] = ~w[2];
        if (!w[2]) begin
            r[1] = ~w[1];
            if (!w[1]) r[3] = ~w[0]; else r[4] = ~w[0];
        end else begin
            r[2] = ~w[1];
            if (!w[1]) r[5] = ~w[0]; else r[6] = ~w[0];
        end
        return r;
    endfunction

    // lower side all locked -> go up; upper side all locked -> go down; else stored
    function automatic logic go_up(input logic lo_full, input logic hi_full, input logic b);
        if (lo_full) return 1'b1;
        if (hi_full) return 1'b0;
        return b;
    endfunction

    function automatic logic [2:0] ref_walk(input logic [6:0] p, input logic [7:0] l);
        logic a, m, f;
        a = go_up(&l[3:0], &l[7:4], p[0]);
        if (!a) begin
            m = go_up(&l[1:0], &l[3:2], p[1]);
            f = m ? go_up(l[2], l[3], p[4]) : go_up(l[0], l[1], p[3]);
        end else begin
            m = go_up(&l[5:4], &l[7:6], p[2]);
            f = m ? go_up(l[6], l[7], p[6]) : go_up(l[4], l[5], p[5]);
        end
        return {a, m, f};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [SW-1:0] s, input logic av, input logic [2:0] w,
                        input logic [7:0] lk, input logic rq, input string tag);
        logic [2:0] e;
        @(negedge clk);
        set_idx = s; acc_valid = av; acc_way = w; lock = lk; victim_req = rq;
        #1;
        e = ref_walk(model[s], lk);
        check({tag, " victim_idx"}, victim_idx, e);
        check({tag, " victim_onehot R6"}, victim_onehot, 8'h01 << e);
        check({tag, " all_locked/valid R8"}, {all_locked, victim_valid},
              {&lk, rq & ~(&lk)});
        @(posedge clk);
        if (av) model[s] = ref_touch(model[s], w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        for (int i = 0; i < NSETS; i++) model[i] = '0;
        // R1: reset state, observed while reset is held and after release
        repeat (2) @(negedge clk);
        for (int s = 0; s < NSETS; s++) begin
            set_idx = SW'(s); #1;
            check("R1 reset victim", victim_idx, 0);
        end
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < NSETS; s++) step(SW'(s), 1'b0, 3'd5, 8'h00, 1'b1, "R1 post-reset");

        // R3: left half locked on zero state -> way 4
        step(0, 1'b0, 0, 8'h0F, 1'b1, "R3 left half locked");
        // R4: pair {0,1} locked on zero state -> way 2
        step(0, 1'b0, 0, 8'h03, 1'b1, "R4 low pair locked");
        step(0, 1'b0, 0, 8'h30, 1'b1, "R4 pair45 locked");
        // R5: way 0 locked -> way 1; way 1 only -> way 0
        step(0, 1'b0, 0, 8'h01, 1'b1, "R5 leaf lower locked");
        step(0, 1'b0, 0, 8'h02, 1'b1, "R5 leaf upper locked");
        // R9: access way 0 in set 3; same-cycle victim still from old state
        step(3, 1'b1, 0, 8'h00, 1'b1, "R9 same-cycle");
        step(3, 1'b0, 0, 8'h00, 1'b1, "R9 next-cycle R2");
        // R3: right half locked with root pointing right -> left side
        step(3, 1'b0, 0, 8'hF0, 1'b1, "R3 right half locked");
        // R10: set 4 unaffected by access to set 3
        step(4, 1'b0, 0, 8'h00, 1'b1, "R10 other set");
        // R11: acc_valid low with nonzero way leaves set 5 at way 0
        step(5, 1'b0, 3'd7, 8'h00, 1'b1, "R11 no access");
        step(5, 1'b0, 3'd7, 8'h00, 1'b1, "R11 still way0");
        // R8: all locked; request low
        step(6, 1'b0, 0, 8'hFF, 1'b1, "R8 all locked");
        step(6, 1'b0, 0, 8'h7F, 1'b0, "R8 no request R7");

        // random: scatter state, then dense locks
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] lk;
            lk = 8'($urandom);
            if ($urandom_range(0, 2) == 0) lk = lk | 8'($urandom);
            if ($urandom_range(0, 5) == 0) lk = 8'h00;
            step(SW'($urandom_range(0, NSETS-1)), 1'($urandom), 3'($urandom), lk,
                 1'($urandom), "R2 R5 R7 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule